// File: doc/BRIEF.md
# Data-Side Tablewalk Assist and TLB Entry Loader

This block is the set of special-purpose registers that a software TLB miss handler works through on the data side of a processor. When a translation lookup misses, the block captures the missed page number and the current address-space ID. The handler then reads two walk registers. Each one returns a ready-made table entry address instead of its stored contents: the first-level pointer, made from the first-level table base and the top ten bits of the missed page, and the second-level pointer, made from the second-level base and the next ten bits of the page.

When the handler has fetched the page table entry, it writes it to the real-page register. That single write commits a whole TLB entry into a 32-entry, fully associative array. The entry is built from the written value together with the current effective-page and walk-control registers. The commit slot comes from an index field in the control register, which moves on by one after every commit. It can be made to skip the top four slots, so that those entries stay resident. A combinational lookup port searches the array, honours three page sizes, and returns the translated address and the entry attributes.

Top module: `tlb_walk_assist`

## Requirements
- R1: After reset the control register reads 0x04000000 (index 0, reserve clear, 4 KB assist set), and no lookup hits until an entry has been committed.
- R2: Register select codes are: 0 control, 1 effective page, 2 context, 3 walk base, 4 walk control, 5 real page. Writes take effect at the clock edge and reads are combinational. Control bits 12:8 hold the load index, bit 27 is reserve and bit 26 is assist; all other control bits read 0. The real-page register reads 0.
- R3: The effective-page register keeps the page number in bits 31:12, an entry-valid flag in bit 9 and a 4-bit address-space ID in bits 3:0. All other bits read 0.
- R4: Reading the walk base returns the stored bits 31:12 with effective-page bits 31:22 placed in bits 11:2 and zeros in bits 1:0.
- R5: Reading walk control returns the stored second-level base (bits 31:12) with effective-page bits 21:12 placed in bits 11:2 and zeros in bits 1:0.
- R6: A write to the real-page register commits an entry at the control index. The entry holds:
  - the page and ID from the effective-page register;
  - page size (bits 3:2), write-through (bit 1), guarded (bit 4) and protection group (bits 8:5) from walk control;
  - real page (bits 31:12) and flags (bits 11:0) from the written value.
  The entry is valid only when effective-page bit 9 and walk-control bit 0 are both 1.
- R7: With reserve clear, every commit advances the index by one, and index 31 wraps to 0.
- R8: With reserve set, the index after a commit from 27 or above is 0, so entries 28 to 31 are never the target of an automatic advance.
- R9: A lookup hits a valid entry whose ID equals the context register and whose page matches the address bits 31:12. Size code 01 (512 KB) ignores the 7 low page bits, size code 11 (8 MB) ignores the 11 low page bits, and codes 00 and 10 compare all 20 bits. The translated address takes the ignored page bits and bits 11:0 from the lookup address. lk_attr is {group[3:0], guarded, write-through}.
- R10: When several entries match, the lowest-numbered entry supplies the result.
- R11: A lookup with lk_valid that misses loads its page into effective-page bits 31:12 and the context value into bits 3:0, and leaves bit 9 unchanged. A register write to the effective page in the same cycle takes priority.
- R12: The context register keeps a 4-bit ID, read back in bits 3:0, which all lookups compare against.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spr_we | input | 1 | Register write strobe |
| spr_sel | input | 3 | Register select for both read and write |
| spr_wdata | input | 32 | Register write data |
| spr_rdata | output | 32 | Register read data (combinational) |
| lk_valid | input | 1 | Lookup is a real access; a miss then latches the page |
| lk_ea | input | 32 | Lookup effective address |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_pa | output | 32 | Translated address (0 on miss) |
| lk_flags | output | 12 | Low bits of the committed real-page value (0 on miss) |
| lk_attr | output | 6 | {group, guarded, write-through} of the hit entry (0 on miss) |

## Verification
The bench fills all 32 slots and reads the index after every commit. A design that mishandles the wrap sends entry 32 to a stale slot, and a design that ignores reserve walks into slots 28 to 31. Large pages are probed with addresses inside and just beyond the block, and size code 10 is probed as a small page. A wrong mask gives a miss where a hit belongs, a false hit, or a translated address with the wrong middle bits. Other probes cover a context mismatch, an entry committed with one of its two valid flags clear, duplicate pages in two slots, and a miss that collides with a register write to the effective page. Any of these errors shows up as a wrong hit flag, a wrong address or a wrong captured page. The walk registers are swept over scattered page values, so a one-bit slip in either index field appears as a wrong pointer.

// File: rtl/tlb_walk_assist.sv
module tlb_walk_assist #(
  parameter int ENTRIES = 32,
  parameter int RSV     = 4,
  parameter int ASID_W  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spr_we,
  input  logic [2:0]  spr_sel,
  input  logic [31:0] spr_wdata,
  output logic [31:0] spr_rdata,
  input  logic        lk_valid,
  input  logic [31:0] lk_ea,
  output logic        lk_hit,
  output logic [31:0] lk_pa,
  output logic [11:0] lk_flags,
  output logic [5:0]  lk_attr
);
  localparam int IDX_W     = $clog2(ENTRIES);
  localparam int LAST      = ENTRIES - 1;
  localparam int KEEP_LAST = ENTRIES - RSV - 1;
  localparam logic [2:0] SEL_CTRL = 3'd0, SEL_EPN = 3'd1, SEL_CTX = 3'd2,
                         SEL_WB = 3'd3, SEL_WC = 3'd4, SEL_RPN = 3'd5;

  logic [IDX_W-1:0]  idx_q, idx_nxt;
  logic              rsv_q, assist_q;
  logic [19:0]       epn_page_q;
  logic              epn_v_q;
  logic [ASID_W-1:0] epn_asid_q, ctx_q;
  logic [19:0]       wb_q, l2b_q;
  logic [3:0]        apg_q;
  logic [1:0]        ps_q;
  logic              grd_q, wt_q, sv_q;

  logic [ENTRIES-1:0] e_v;
  logic [19:0]        e_vpn  [ENTRIES];
  logic [19:0]        e_rpn  [ENTRIES];
  logic [19:0]        e_mask [ENTRIES];
  logic [ASID_W-1:0]  e_asid [ENTRIES];
  logic [1:0]         e_ps   [ENTRIES];
  logic [11:0]        e_flg  [ENTRIES];
  logic [5:0]         e_attr [ENTRIES];

  logic [ENTRIES-1:0] match;
  logic [IDX_W-1:0]   hit_idx;

  wire wr_ctrl = spr_we && spr_sel == SEL_CTRL;
  wire wr_epn  = spr_we && spr_sel == SEL_EPN;
  wire wr_ctx  = spr_we && spr_sel == SEL_CTX;
  wire wr_wb   = spr_we && spr_sel == SEL_WB;
  wire wr_wc   = spr_we && spr_sel == SEL_WC;
  wire wr_rpn  = spr_we && spr_sel == SEL_RPN;

  always_comb begin
    if (rsv_q)
      idx_nxt = (idx_q >= IDX_W'(KEEP_LAST)) ? '0 : idx_q + 1'b1;
    else
      idx_nxt = (idx_q == IDX_W'(LAST)) ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q    <= '0;
      rsv_q    <= 1'b0;
      assist_q <= 1'b1;
    end else if (wr_ctrl) begin
      idx_q    <= spr_wdata[8 +: IDX_W];
      rsv_q    <= spr_wdata[27];
      assist_q <= spr_wdata[26];
    end else if (wr_rpn) begin
      idx_q    <= idx_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epn_page_q <= '0;
      epn_v_q    <= 1'b0;
      epn_asid_q <= '0;
      ctx_q      <= '0;
      wb_q       <= '0;
      l2b_q      <= '0;
      apg_q      <= '0;
      ps_q       <= '0;
      grd_q      <= 1'b0;
      wt_q       <= 1'b0;
      sv_q       <= 1'b0;
    end else begin
      if (wr_epn) begin
        epn_page_q <= spr_wdata[31:12];
        epn_v_q    <= spr_wdata[9];
        epn_asid_q <= spr_wdata[ASID_W-1:0];
      end else if (lk_valid && !lk_hit) begin
        epn_page_q <= lk_ea[31:12];
        epn_asid_q <= ctx_q;
      end
      if (wr_ctx) ctx_q <= spr_wdata[ASID_W-1:0];
      if (wr_wb)  wb_q  <= spr_wdata[31:12];
      if (wr_wc) begin
        l2b_q <= spr_wdata[31:12];
        apg_q <= spr_wdata[8:5];
        grd_q <= spr_wdata[4];
        ps_q  <= spr_wdata[3:2];
        wt_q  <= spr_wdata[1];
        sv_q  <= spr_wdata[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        e_v[i]    <= 1'b0;
        e_vpn[i]  <= '0;
        e_rpn[i]  <= '0;
        e_asid[i] <= '0;
        e_ps[i]   <= '0;
        e_flg[i]  <= '0;
        e_attr[i] <= '0;
      end
    end else if (wr_rpn) begin
      e_v[idx_q]    <= epn_v_q & sv_q;
      e_vpn[idx_q]  <= epn_page_q;
      e_asid[idx_q] <= epn_asid_q;
      e_ps[idx_q]   <= ps_q;
      e_rpn[idx_q]  <= spr_wdata[31:12];
      e_flg[idx_q]  <= spr_wdata[11:0];
      e_attr[idx_q] <= {apg_q, grd_q, wt_q};
    end
  end

  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_cmp
    assign e_mask[gi] = (e_ps[gi] == 2'b11) ? 20'h007FF :
                        (e_ps[gi] == 2'b01) ? 20'h0007F : 20'h00000;
    assign match[gi]  = e_v[gi] && (e_asid[gi] == ctx_q) &&
                        (((e_vpn[gi] ^ lk_ea[31:12]) & ~e_mask[gi]) == 20'h0);
  end

  always_comb begin
    lk_hit  = 1'b0;
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        lk_hit  = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  assign lk_pa    = lk_hit ? {(e_rpn[hit_idx] & ~e_mask[hit_idx]) |
                              (lk_ea[31:12] & e_mask[hit_idx]), lk_ea[11:0]} : 32'h0;
  assign lk_flags = lk_hit ? e_flg[hit_idx]  : 12'h0;
  assign lk_attr  = lk_hit ? e_attr[hit_idx] : 6'h0;

  always_comb begin
    spr_rdata = 32'h0;
    case (spr_sel)
      SEL_CTRL: begin
        spr_rdata[27]          = rsv_q;
        spr_rdata[26]          = assist_q;
        spr_rdata[8 +: IDX_W]  = idx_q;
      end
      SEL_EPN: begin
        spr_rdata[31:12]       = epn_page_q;
        spr_rdata[9]           = epn_v_q;
        spr_rdata[ASID_W-1:0]  = epn_asid_q;
      end
      SEL_CTX: spr_rdata[ASID_W-1:0] = ctx_q;
      SEL_WB:  spr_rdata = {wb_q,  epn_page_q[19:10], 2'b00};
      SEL_WC:  spr_rdata = {l2b_q, epn_page_q[9:0],   2'b00};
      default: spr_rdata = 32'h0;
    endcase
  end

  // R1
  ctrl_reset_chk: assert property (@(posedge clk)
    !rst_n |=> (idx_q == '0 && !rsv_q && assist_q && e_v == '0));

  // R6
  commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rpn |=> (e_vpn[$past(idx_q)] == $past(epn_page_q) &&
                e_rpn[$past(idx_q)] == $past(spr_wdata[31:12])));

  // R7
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rpn && !rsv_q && idx_q == IDX_W'(LAST)) |=> idx_q == '0);

  // R8
  idx_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rpn && rsv_q) |=> idx_q <= IDX_W'(KEEP_LAST));

  // R11
  miss_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_hit && !wr_epn) |=>
      (epn_page_q == $past(lk_ea[31:12]) && epn_asid_q == $past(ctx_q)));
endmodule

// File: tb/tlb_walk_assist_bench.sv
module tlb_walk_assist_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spr_we = 1'b0;
  logic [2:0]  spr_sel = 3'd0;
  logic [31:0] spr_wdata = 32'h0;
  logic [31:0] spr_rdata;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_ea = 32'h0;
  logic        lk_hit;
  logic [31:0] lk_pa;
  logic [11:0] lk_flags;
  logic [5:0]  lk_attr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tlb_walk_assist u_tlb_walk_assist (
    .clk(clk), .rst_n(rst_n), .spr_we(spr_we), .spr_sel(spr_sel),
    .spr_wdata(spr_wdata), .spr_rdata(spr_rdata), .lk_valid(lk_valid),
    .lk_ea(lk_ea), .lk_hit(lk_hit), .lk_pa(lk_pa), .lk_flags(lk_flags),
    .lk_attr(lk_attr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    spr_we = 1'b1; spr_sel = sel; spr_wdata = d;
    @(negedge clk);
    spr_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [31:0] d);
    @(negedge clk);
    spr_sel = sel;
    #1 d = spr_rdata;
  endtask

  task automatic look(input logic [31:0] ea, input bit latch,
                      output logic h, output logic [31:0] pa,
                      output logic [11:0] fl, output logic [5:0] at);
    @(negedge clk);
    lk_ea = ea; lk_valid = latch;
    #1 h = lk_hit; pa = lk_pa; fl = lk_flags; at = lk_attr;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic load(input logic [19:0] page, input logic [3:0] asid, input bit ev,
                      input logic [31:0] twc, input logic [31:0] rpn);
    wr(3'd1, {page, 2'b00, ev, 5'b0, asid});
    wr(3'd4, twc);
    wr(3'd5, rpn);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, pa, ea;
    logic [11:0] fl;
    logic [5:0]  at;
    logic        h;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(3'd0, d);  chk("R1 control reset", d, 32'h0400_0000);
    look(32'h1000_0000, 1'b0, h, pa, fl, at);
    chk("R1 no hit after reset", {31'h0, h}, 32'h0);
    chk("R1 pa zero on miss", pa, 32'h0);
    rd(3'd5, d);  chk("R2 real page reads zero", d, 32'h0);

    wr(3'd2, 32'h0000_0005);
    rd(3'd2, d);  chk("R12 context readback", d, 32'h5);

    for (int i = 0; i < 32; i++) begin
      logic [31:0] twc;
      twc = {20'h0, 3'b0, 4'(i), i[0], 2'b00, i[1], 1'b1};
      load(20'h10000 + 20'(i * 3), 4'd5, 1'b1, twc,
           ((32'h80000 + 32'(i)) << 12) | 32'((i * 37) & 12'hFFF));
      rd(3'd0, d);
      chk("R7 index advance", d, 32'h0400_0000 | (32'((i + 1) % 32) << 8));
    end
    for (int i = 0; i < 32; i++) begin
      ea = ((32'h10000 + 32'(i * 3)) << 12) | 32'(i * 4 + 1);
      look(ea, 1'b0, h, pa, fl, at);
      chk("R6 committed entry hits", {31'h0, h}, 32'h1);
      chk("R9 translated address", pa, ((32'h80000 + 32'(i)) << 12) | 32'(i * 4 + 1));
      chk("R6 flags", {20'h0, fl}, 32'((i * 37) & 12'hFFF));
      chk("R6 attributes", {26'h0, at}, {26'h0, 4'(i), i[0], i[1]});
    end

    wr(3'd2, 32'h0000_0006);
    look(32'h1000_0000, 1'b1, h, pa, fl, at);
    chk("R9 context mismatch misses", {31'h0, h}, 32'h0);
    rd(3'd1, d);  chk("R11 miss latches page and id", d, 32'h1000_0206);
    wr(3'd2, 32'h0000_0005);

    wr(3'd3, 32'hABCD_E123);
    wr(3'd4, 32'h1234_51FF);
    for (int k = 0; k < 16; k++) begin
      ea = 32'h9E37_79B9 * 32'(k + 1);
      wr(3'd1, ea);
      rd(3'd1, d);  chk("R3 effective page fields", d, (ea & 32'hFFFF_F000) | (ea & 32'h200) | (ea & 32'hF));
      rd(3'd3, d);  chk("R4 first-level pointer", d, 32'hABCD_E000 | ((ea >> 22) << 2));
      rd(3'd4, d);  chk("R5 second-level pointer", d, 32'h1234_5000 | (((ea >> 12) & 32'h3FF) << 2));
    end

    wr(3'd0, 32'h0800_0000 | (32'd26 << 8));
    rd(3'd0, d);  chk("R2 control fields", d, 32'h0800_1A00);
    load(20'h30000, 4'd5, 1'b1, 32'h1, 32'h3000_0000);
    rd(3'd0, d);  chk("R8 reserve 26->27", d, 32'h0800_1B00);
    load(20'h30000, 4'd5, 1'b1, 32'h1, 32'h3000_0000);
    rd(3'd0, d);  chk("R8 reserve 27->0", d, 32'h0800_0000);
    load(20'h30000, 4'd5, 1'b1, 32'h1, 32'h3000_0000);
    rd(3'd0, d);  chk("R8 reserve 0->1", d, 32'h0800_0100);
    wr(3'd0, 32'h0800_0000 | (32'd29 << 8));
    load(20'h30000, 4'd5, 1'b1, 32'h1, 32'h3000_0000);
    rd(3'd0, d);  chk("R8 reserve from 29 ->0", d, 32'h0800_0000);

    wr(3'd0, 32'd5 << 8);
    load(20'h40080, 4'd5, 1'b1, 32'h5, 32'h9000_0000);
    look(32'h400D_4321, 1'b0, h, pa, fl, at);
    chk("R9 512K hit", {31'h0, h}, 32'h1);
    chk("R9 512K address", pa, 32'h9005_4321);
    look(32'h4010_0321, 1'b0, h, pa, fl, at);
    chk("R9 512K outside misses", {31'h0, h}, 32'h0);
    load(20'h80000, 4'd5, 1'b1, 32'hD, 32'hA000_0000);
    look(32'h807A_BCDE, 1'b0, h, pa, fl, at);
    chk("R9 8M address", pa, 32'hA07A_BCDE);
    look(32'h8080_0000, 1'b0, h, pa, fl, at);
    chk("R9 8M outside misses", {31'h0, h}, 32'h0);
    load(20'hC0000, 4'd5, 1'b1, 32'h9, 32'hB000_0000);
    look(32'hC000_1000, 1'b0, h, pa, fl, at);
    chk("R9 code 10 compares all bits", {31'h0, h}, 32'h0);
    look(32'hC000_0ABC, 1'b0, h, pa, fl, at);
    chk("R9 code 10 small page address", pa, 32'hB000_0ABC);

    load(20'hD0000, 4'd5, 1'b0, 32'h1, 32'hC000_0000);
    look(32'hD000_0000, 1'b0, h, pa, fl, at);
    chk("R6 entry-valid clear misses", {31'h0, h}, 32'h0);
    load(20'hD1000, 4'd5, 1'b1, 32'h0, 32'hC000_0000);
    look(32'hD100_0000, 1'b0, h, pa, fl, at);
    chk("R6 segment-valid clear misses", {31'h0, h}, 32'h0);

    wr(3'd0, 32'd10 << 8);
    load(20'h55555, 4'd5, 1'b1, 32'h1, 32'h1111_1000);
    wr(3'd0, 32'd3 << 8);
    load(20'h55555, 4'd5, 1'b1, 32'h1, 32'h2222_2000);
    look(32'h5555_5008, 1'b0, h, pa, fl, at);
    chk("R10 lowest entry wins", pa, 32'h2222_2008);

    @(negedge clk);
    spr_we = 1'b1; spr_sel = 3'd1; spr_wdata = 32'h7777_7202;
    lk_ea = 32'hEEEE_E000; lk_valid = 1'b1;
    @(negedge clk);
    spr_we = 1'b0; lk_valid = 1'b0;
    rd(3'd1, d);  chk("R11 register write beats miss latch", d, 32'h7777_7202);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule